// File: doc/BRIEF.md
# Set-Associative Translation Buffer with Global Entries

This block keeps recently used virtual-to-physical page translations so that most address translations avoid a walk of the in-memory page tables. A requester presents a virtual page number on the lookup port. One cycle later the block answers with a hit flag, the physical page number and three permission attributes: writable, user and dirty. When the lookup misses, the block raises a walk request towards an external page-walk unit. That unit answers on the fill port, which writes the returned entry into the array.

The array has 16 sets of 4 ways. Three maintenance inputs keep the array consistent with the page tables:
- A base-register reload flush drops every entry that is not marked global.
- A single-page invalidate drops the entry for one virtual page, whether or not it is global.
- A physical snoop drops every entry that points at a given physical page, for use when that page is swapped out.

Each set picks its replacement victim with a three-bit tree pseudo-LRU.

Top module: `xlat_tlb`

## Requirements
- R1: Each cycle with `lk_valid` high gives `rsp_valid` high in the next cycle. A cycle with `lk_valid` low gives `rsp_valid` low in the next cycle.
- R2: The set index is `lk_vpn[3:0]` and the tag is `lk_vpn[19:4]`. Up to four translations with the same low four bits can be held at once, and translations in different sets do not disturb each other.
- R3: On a hit, `rsp_ppn`, `rsp_writable`, `rsp_user` and `rsp_dirty` equal the values of the most recent fill for that virtual page.
- R4: A miss returns `rsp_hit` low. In the same response cycle `walk_req` is high with `walk_vpn` set to the missed page. Both hold, and later misses do not change `walk_vpn`, until a cycle with `fill_valid` high. After that cycle `walk_req` is low.
- R5: A fill into a set that still has a free way evicts nothing. A fill of a virtual page that is already present replaces its translation in place, without a second copy.
- R6: A fill into a full set replaces a victim chosen by a tree pseudo-LRU. Each set holds three bits, all zero after reset:
  - bit 0 selects the victim pair: 0 picks ways 0–1, 1 picks ways 2–3.
  - bit 1 selects within ways 0–1: 0 picks way 0.
  - bit 2 selects within ways 2–3: 0 picks way 2.
  - Every hit and every fill to a way sets the bits to point away from that way.
  - Free ways are taken lowest index first.
- R7: A cycle with `flush_nonglobal` high invalidates every entry whose fill had `fill_global` low. Global entries keep hitting.
- R8: `inv_valid` removes the entry for `inv_vpn` even if it is global. Other entries of the same set keep hitting.
- R9: `snoop_valid` removes every entry, in any set, whose physical page equals `snoop_ppn`.
- R10: A lookup issued in the same cycle as a flush, an invalidate or a snoop sees the state after that maintenance.
- R11: After reset no entry is valid, and `rsp_valid` and `walk_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | 20 | Virtual page number to translate |
| rsp_valid | output | 1 | Response valid, one cycle after a request |
| rsp_hit | output | 1 | Translation found |
| rsp_ppn | output | 20 | Physical page number on a hit, zero otherwise |
| rsp_writable | output | 1 | Page may be written |
| rsp_user | output | 1 | Page is reachable at user privilege |
| rsp_dirty | output | 1 | Page has been written |
| walk_req | output | 1 | Page walk requested |
| walk_vpn | output | 20 | Virtual page number to walk |
| fill_valid | input | 1 | Install an entry |
| fill_vpn | input | 20 | Virtual page of the entry |
| fill_ppn | input | 20 | Physical page of the entry |
| fill_writable | input | 1 | Writable attribute |
| fill_user | input | 1 | User attribute |
| fill_dirty | input | 1 | Dirty attribute |
| fill_global | input | 1 | Entry survives a base-register reload |
| flush_nonglobal | input | 1 | Drop all non-global entries |
| inv_valid | input | 1 | Single-page invalidate |
| inv_vpn | input | 20 | Virtual page to invalidate |
| snoop_valid | input | 1 | Physical snoop invalidate |
| snoop_ppn | input | 20 | Physical page being removed |

## Verification
A full sweep fills all 64 entries. Each tag is derived from its way number and each physical page from its virtual page, so a wrong set index, tag slice or way multiplexer shows up as a wrong or missing translation.

The replacement check works on a single set over many rounds. Each round uses a different pattern of hits, and a model of the three tree bits predicts the victim. This separates a true tree pseudo-LRU from round-robin or fixed-way replacement.

The maintenance checks mix global and non-global entries, and one physical page is aliased from two sets. A reload flush must leave exactly the global entries, an invalidate must remove a global entry, and a snoop must reach across sets. Lookups issued in the same cycle as the maintenance show whether the lookup sees the state after it.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  localparam int WAYS  = 4;
  localparam int WAY_W = 2;

  typedef struct packed {
    logic writable;
    logic user;
    logic dirty;
  } tlb_attr_t;

  // Tree state: [0] pair pointer, [1] pointer inside ways 0-1, [2] inside ways 2-3.
  function automatic logic [2:0] plru_touch(input logic [2:0] st, input logic [WAY_W-1:0] way);
    logic [2:0] r;
    r = st;
    if (!way[1]) begin
      r[0] = 1'b1;
      r[1] = ~way[0];
    end else begin
      r[0] = 1'b0;
      r[2] = ~way[0];
    end
    return r;
  endfunction

  function automatic logic [WAY_W-1:0] plru_victim(input logic [2:0] st);
    return st[0] ? {1'b1, st[2]} : {1'b0, st[1]};
  endfunction

  // Returns {found, lowest free way index}.
  function automatic logic [WAY_W:0] first_free(input logic [WAYS-1:0] vld);
    logic [WAY_W:0] r;
    r = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!vld[w]) r = {1'b1, WAY_W'(w)};
    end
    return r;
  endfunction

endpackage

// File: rtl/tlb_store.sv
module tlb_store
  import tlb_pkg::*;
#(
  parameter int SETS  = 16,
  parameter int TAG_W = 16,
  parameter int PPN_W = 20,
  localparam int SET_W = $clog2(SETS)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             flush,
  input  logic                             inv_en,
  input  logic [SET_W-1:0]                 inv_set,
  input  logic [TAG_W-1:0]                 inv_tag,
  input  logic                             snoop_en,
  input  logic [PPN_W-1:0]                 snoop_ppn,
  input  logic                             wr_en,
  input  logic [SET_W-1:0]                 wr_set,
  input  logic [WAY_W-1:0]                 wr_way,
  input  logic [TAG_W-1:0]                 wr_tag,
  input  logic [PPN_W-1:0]                 wr_ppn,
  input  tlb_attr_t                        wr_attr,
  input  logic                             wr_glob,
  input  logic [SET_W-1:0]                 rd_set,
  output logic [WAYS-1:0]                  rd_live,
  output logic [WAYS-1:0][TAG_W-1:0]       rd_tag,
  output logic [WAYS-1:0][PPN_W-1:0]       rd_ppn,
  output tlb_attr_t [WAYS-1:0]             rd_attr,
  output logic [WAYS-1:0]                  wr_set_valid,
  output logic [WAYS-1:0][TAG_W-1:0]       wr_set_tag
);

  logic [WAYS-1:0]            valid_q [SETS];
  logic [WAYS-1:0]            glob_q  [SETS];
  logic [WAYS-1:0][TAG_W-1:0] tag_q   [SETS];
  logic [WAYS-1:0][PPN_W-1:0] ppn_q   [SETS];
  tlb_attr_t [WAYS-1:0]       attr_q  [SETS];

  // Entries removed by this cycle's maintenance.
  logic [WAYS-1:0] kill [SETS];

  always_comb begin
    for (int s = 0; s < SETS; s++) begin
      for (int w = 0; w < WAYS; w++) begin
        kill[s][w] = (flush && !glob_q[s][w])
                   || (inv_en && inv_set == SET_W'(s) && tag_q[s][w] == inv_tag)
                   || (snoop_en && ppn_q[s][w] == snoop_ppn);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        glob_q[s]  <= '0;
      end
    end else begin
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= valid_q[s] & ~kill[s];
      end
      if (wr_en) begin
        valid_q[wr_set][wr_way] <= 1'b1;
        glob_q[wr_set][wr_way]  <= wr_glob;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_set][wr_way]  <= wr_tag;
      ppn_q[wr_set][wr_way]  <= wr_ppn;
      attr_q[wr_set][wr_way] <= wr_attr;
    end
  end

  assign rd_live      = valid_q[rd_set] & ~kill[rd_set];
  assign rd_tag       = tag_q[rd_set];
  assign rd_ppn       = ppn_q[rd_set];
  assign rd_attr      = attr_q[rd_set];
  assign wr_set_valid = valid_q[wr_set];
  assign wr_set_tag   = tag_q[wr_set];

  logic any_local_live;
  always_comb begin
    any_local_live = 1'b0;
    for (int s = 0; s < SETS; s++) begin
      any_local_live = any_local_live || |(valid_q[s] & ~glob_q[s]);
    end
  end

  AST_FLUSH_SPARES_ONLY_GLOBAL: assert property (@(posedge clk) disable iff (!rst_n)
    flush && !wr_en |=> !any_local_live); // R7

endmodule

// File: rtl/tlb_plru.sv
module tlb_plru
  import tlb_pkg::*;
#(
  parameter int SETS = 16,
  localparam int SET_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit_en,
  input  logic [SET_W-1:0] hit_set,
  input  logic [WAY_W-1:0] hit_way,
  input  logic             fill_en,
  input  logic [SET_W-1:0] fill_set,
  input  logic [WAY_W-1:0] fill_way,
  input  logic [SET_W-1:0] vic_set,
  output logic [WAY_W-1:0] vic_way
);

  logic [2:0] st_q [SETS];
  logic [2:0] st_d [SETS];

  always_comb begin
    for (int s = 0; s < SETS; s++) begin
      st_d[s] = st_q[s];
      if (hit_en && hit_set == SET_W'(s))   st_d[s] = plru_touch(st_d[s], hit_way);
      if (fill_en && fill_set == SET_W'(s)) st_d[s] = plru_touch(st_d[s], fill_way);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) st_q[s] <= '0;
    end else begin
      for (int s = 0; s < SETS; s++) st_q[s] <= st_d[s];
    end
  end

  assign vic_way = plru_victim(st_q[vic_set]);

  AST_FILLED_WAY_NOT_NEXT_VICTIM: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |=> plru_victim(st_q[$past(fill_set)]) != $past(fill_way)); // R6

endmodule

// File: rtl/tlb_match.sv
module tlb_match
  import tlb_pkg::*;
#(
  parameter int TAG_W = 16,
  parameter int PPN_W = 20
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [TAG_W-1:0]           req_tag,
  input  logic [WAYS-1:0]            live,
  input  logic [WAYS-1:0][TAG_W-1:0] tags,
  input  logic [WAYS-1:0][PPN_W-1:0] ppns,
  input  tlb_attr_t [WAYS-1:0]       attrs,
  output logic                       hit,
  output logic [WAY_W-1:0]           hit_way,
  output logic [PPN_W-1:0]           ppn,
  output tlb_attr_t                  attr
);

  logic [WAYS-1:0] way_match;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign way_match[w] = live[w] && tags[w] == req_tag;
  end

  always_comb begin
    hit_way = '0;
    ppn     = '0;
    attr    = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (way_match[w]) begin
        hit_way = WAY_W'(w);
        ppn     = ppns[w];
        attr    = attrs[w];
      end
    end
  end

  assign hit = |way_match;

  AST_SINGLE_MATCHING_WAY: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(way_match)); // R5

endmodule

// File: rtl/xlat_tlb.sv
module xlat_tlb
  import tlb_pkg::*;
#(
  parameter int VPN_W = 20,
  parameter int PPN_W = 20,
  parameter int SETS  = 16,
  localparam int SET_W = $clog2(SETS),
  localparam int TAG_W = VPN_W - SET_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_valid,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic [PPN_W-1:0] rsp_ppn,
  output logic             rsp_writable,
  output logic             rsp_user,
  output logic             rsp_dirty,
  output logic             walk_req,
  output logic [VPN_W-1:0] walk_vpn,
  input  logic             fill_valid,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic             fill_writable,
  input  logic             fill_user,
  input  logic             fill_dirty,
  input  logic             fill_global,
  input  logic             flush_nonglobal,
  input  logic             inv_valid,
  input  logic [VPN_W-1:0] inv_vpn,
  input  logic             snoop_valid,
  input  logic [PPN_W-1:0] snoop_ppn
);

  wire [SET_W-1:0] lk_set   = lk_vpn[SET_W-1:0];
  wire [TAG_W-1:0] lk_tag   = lk_vpn[VPN_W-1:SET_W];
  wire [SET_W-1:0] fill_set = fill_vpn[SET_W-1:0];
  wire [TAG_W-1:0] fill_tag = fill_vpn[VPN_W-1:SET_W];

  tlb_attr_t fill_attr;
  assign fill_attr = '{writable: fill_writable, user: fill_user, dirty: fill_dirty};

  logic [WAYS-1:0]            rd_live;
  logic [WAYS-1:0][TAG_W-1:0] rd_tag;
  logic [WAYS-1:0][PPN_W-1:0] rd_ppn;
  tlb_attr_t [WAYS-1:0]       rd_attr;
  logic [WAYS-1:0]            fs_valid;
  logic [WAYS-1:0][TAG_W-1:0] fs_tag;
  logic [WAY_W-1:0]           fill_way;
  logic [WAY_W-1:0]           victim_way;

  tlb_store #(.SETS(SETS), .TAG_W(TAG_W), .PPN_W(PPN_W)) i_store (
    .clk          (clk),
    .rst_n        (rst_n),
    .flush        (flush_nonglobal),
    .inv_en       (inv_valid),
    .inv_set      (inv_vpn[SET_W-1:0]),
    .inv_tag      (inv_vpn[VPN_W-1:SET_W]),
    .snoop_en     (snoop_valid),
    .snoop_ppn    (snoop_ppn),
    .wr_en        (fill_valid),
    .wr_set       (fill_set),
    .wr_way       (fill_way),
    .wr_tag       (fill_tag),
    .wr_ppn       (fill_ppn),
    .wr_attr      (fill_attr),
    .wr_glob      (fill_global),
    .rd_set       (lk_set),
    .rd_live      (rd_live),
    .rd_tag       (rd_tag),
    .rd_ppn       (rd_ppn),
    .rd_attr      (rd_attr),
    .wr_set_valid (fs_valid),
    .wr_set_tag   (fs_tag)
  );

  // Lookup path: compare against the post-maintenance view of the set.
  logic             lk_hit_now;
  logic [WAY_W-1:0] lk_hit_way;
  logic [PPN_W-1:0] lk_ppn;
  tlb_attr_t        lk_attr;

  tlb_match #(.TAG_W(TAG_W), .PPN_W(PPN_W)) i_match (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_tag (lk_tag),
    .live    (rd_live),
    .tags    (rd_tag),
    .ppns    (rd_ppn),
    .attrs   (rd_attr),
    .hit     (lk_hit_now),
    .hit_way (lk_hit_way),
    .ppn     (lk_ppn),
    .attr    (lk_attr)
  );

  wire lk_touch    = lk_valid && lk_hit_now;
  wire lk_miss_now = lk_valid && !lk_hit_now;

  // Fill way choice: same page in place, else lowest free way, else tree victim.
  logic [WAYS-1:0] fill_dup;
  for (genvar w = 0; w < WAYS; w++) begin : g_dup
    assign fill_dup[w] = fs_valid[w] && fs_tag[w] == fill_tag;
  end

  logic [WAY_W:0]   fill_free;
  logic [WAY_W-1:0] dup_way;
  assign fill_free = first_free(fs_valid);

  always_comb begin
    dup_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (fill_dup[w]) dup_way = WAY_W'(w);
    end
  end

  assign fill_way = (|fill_dup)       ? dup_way :
                    fill_free[WAY_W]  ? fill_free[WAY_W-1:0] : victim_way;

  tlb_plru #(.SETS(SETS)) i_plru (
    .clk      (clk),
    .rst_n    (rst_n),
    .hit_en   (lk_touch),
    .hit_set  (lk_set),
    .hit_way  (lk_hit_way),
    .fill_en  (fill_valid),
    .fill_set (fill_set),
    .fill_way (fill_way),
    .vic_set  (fill_set),
    .vic_way  (victim_way)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid    <= 1'b0;
      rsp_hit      <= 1'b0;
      rsp_ppn      <= '0;
      rsp_writable <= 1'b0;
      rsp_user     <= 1'b0;
      rsp_dirty    <= 1'b0;
    end else begin
      rsp_valid    <= lk_valid;
      rsp_hit      <= lk_touch;
      rsp_ppn      <= lk_touch ? lk_ppn : '0;
      rsp_writable <= lk_touch && lk_attr.writable;
      rsp_user     <= lk_touch && lk_attr.user;
      rsp_dirty    <= lk_touch && lk_attr.dirty;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      walk_req <= 1'b0;
      walk_vpn <= '0;
    end else begin
      if (fill_valid) walk_req <= 1'b0;
      if (lk_miss_now && (!walk_req || fill_valid)) begin
        walk_req <= 1'b1;
        walk_vpn <= lk_vpn;
      end
    end
  end

  AST_REQ_GIVES_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rsp_valid); // R1
  AST_NO_RSP_WITHOUT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !rsp_valid); // R1
  AST_MISS_RAISES_WALK: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_hit |-> walk_req); // R4
  AST_WALK_HELD_TO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    walk_req && !fill_valid |=> walk_req && $stable(walk_vpn)); // R4
  AST_MISS_RETURNS_ZERO_PPN: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_hit |-> rsp_ppn == '0); // R3

endmodule

// File: tb/test_xlat_tlb.sv
module test_xlat_tlb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        lk_valid;
  logic [19:0] lk_vpn;
  logic        rsp_valid, rsp_hit, rsp_writable, rsp_user, rsp_dirty;
  logic [19:0] rsp_ppn;
  logic        walk_req;
  logic [19:0] walk_vpn;
  logic        fill_valid;
  logic [19:0] fill_vpn, fill_ppn;
  logic        fill_writable, fill_user, fill_dirty, fill_global;
  logic        flush_nonglobal, inv_valid, snoop_valid;
  logic [19:0] inv_vpn, snoop_ppn;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk; // 50 MHz

  xlat_tlb i_xlat_tlb (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_vpn(lk_vpn),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_ppn(rsp_ppn),
    .rsp_writable(rsp_writable), .rsp_user(rsp_user), .rsp_dirty(rsp_dirty),
    .walk_req(walk_req), .walk_vpn(walk_vpn),
    .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
    .fill_writable(fill_writable), .fill_user(fill_user), .fill_dirty(fill_dirty),
    .fill_global(fill_global),
    .flush_nonglobal(flush_nonglobal),
    .inv_valid(inv_valid), .inv_vpn(inv_vpn),
    .snoop_valid(snoop_valid), .snoop_ppn(snoop_ppn)
  );

  function automatic logic [19:0] vpn_of(input int s, input int k);
    return {16'((k + 1) * 16'h0123), 4'(s)};
  endfunction

  function automatic logic [19:0] ppn_of(input logic [19:0] v);
    return 20'(v * 7 + 19);
  endfunction

  function automatic logic [2:0] attr_of(input logic [19:0] v);
    return v[2:0] ^ v[6:4];
  endfunction

  // Tree bits: [0] pair, [1] inside 0-1, [2] inside 2-3
  function automatic logic [2:0] m_touch(input logic [2:0] b, input int w);
    logic [2:0] r;
    r = b;
    r[0] = (w < 2);
    if (w < 2) r[1] = (w == 0);
    else       r[2] = (w == 2);
    return r;
  endfunction

  function automatic int m_victim(input logic [2:0] b);
    if (b[0]) return b[2] ? 3 : 2;
    return b[1] ? 1 : 0;
  endfunction

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  task automatic idle_inputs();
    lk_valid = 0; lk_vpn = '0;
    fill_valid = 0; fill_vpn = '0; fill_ppn = '0;
    fill_writable = 0; fill_user = 0; fill_dirty = 0; fill_global = 0;
    flush_nonglobal = 0; inv_valid = 0; inv_vpn = '0;
    snoop_valid = 0; snoop_ppn = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    idle_inputs();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
  endtask

  task automatic fill(input logic [19:0] v, input logic [19:0] p, input bit g);
    @(negedge clk);
    fill_valid = 1; fill_vpn = v; fill_ppn = p; fill_global = g;
    {fill_writable, fill_user, fill_dirty} = attr_of(v);
    @(negedge clk);
    fill_valid = 0;
  endtask

  // Lookup, optionally with a flush or invalidate in the same cycle.
  task automatic look(input logic [19:0] v, input bit fl, input bit inv, input logic [19:0] iv,
                      output bit h, output logic [19:0] p, output logic [2:0] a, output bit rv);
    @(negedge clk);
    lk_valid = 1; lk_vpn = v;
    flush_nonglobal = fl; inv_valid = inv; inv_vpn = iv;
    @(negedge clk);
    lk_valid = 0; flush_nonglobal = 0; inv_valid = 0;
    h = rsp_hit; p = rsp_ppn; a = {rsp_writable, rsp_user, rsp_dirty}; rv = rsp_valid;
  endtask

  task automatic expect_entry(input string rq, input logic [19:0] v, input bit eh,
                              input logic [19:0] ep);
    bit h, rv;
    logic [19:0] p;
    logic [2:0] a;
    look(v, 0, 0, '0, h, p, a, rv);
    chk(rq, {31'd0, h}, {31'd0, eh});
    if (eh) begin
      chk({rq, " ppn"}, {12'd0, p}, {12'd0, ep});
      chk({rq, " attr"}, {29'd0, a}, {29'd0, attr_of(v)});
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    bit h, rv;
    logic [19:0] p, va, vb;
    logic [2:0] a;
    logic [2:0] mb;
    logic [19:0] way_vpn [4];

    rst_n = 0;
    idle_inputs();
    do_reset();

    // R11: reset state
    chk("R11 rsp_valid", {31'd0, rsp_valid}, 0);
    chk("R11 walk_req", {31'd0, walk_req}, 0);

    // R1: response timing
    @(negedge clk);
    chk("R1 idle no rsp", {31'd0, rsp_valid}, 0);
    look(vpn_of(1, 0), 0, 0, '0, h, p, a, rv);
    chk("R1 rsp after req", {31'd0, rv}, 1);
    @(negedge clk);
    chk("R1 rsp drops", {31'd0, rsp_valid}, 0);

    // R4: miss and walk request
    do_reset();
    va = vpn_of(2, 5);
    vb = vpn_of(7, 1);
    look(va, 0, 0, '0, h, p, a, rv);
    chk("R4 miss", {31'd0, h}, 0);
    chk("R4 walk_req", {31'd0, walk_req}, 1);
    chk("R4 walk_vpn", {12'd0, walk_vpn}, {12'd0, va});
    look(vb, 0, 0, '0, h, p, a, rv);
    chk("R4 second miss", {31'd0, h}, 0);
    chk("R4 walk_vpn held", {12'd0, walk_vpn}, {12'd0, va});
    fill(va, ppn_of(va), 0);
    chk("R4 walk_req cleared", {31'd0, walk_req}, 0);
    expect_entry("R4 hit after fill", va, 1, ppn_of(va));

    // R2, R3: full sweep of all sets and ways, way 0 global
    do_reset();
    for (int s = 0; s < 16; s++)
      for (int k = 0; k < 4; k++)
        fill(vpn_of(s, k), ppn_of(vpn_of(s, k)), k == 0);
    for (int s = 0; s < 16; s++)
      for (int k = 0; k < 4; k++)
        expect_entry("R2 R3 sweep", vpn_of(s, k), 1, ppn_of(vpn_of(s, k)));

    // R7: reload flush keeps only global entries
    @(negedge clk);
    flush_nonglobal = 1;
    @(negedge clk);
    flush_nonglobal = 0;
    for (int s = 0; s < 16; s++)
      for (int k = 0; k < 4; k++)
        expect_entry("R7 flush", vpn_of(s, k), k == 0, ppn_of(vpn_of(s, k)));

    // R11: reset clears everything
    do_reset();
    expect_entry("R11 empty after reset", vpn_of(0, 0), 0, '0);

    // R5: refill in place, free ways never evict
    do_reset();
    for (int r = 0; r < 4; r++) fill(vpn_of(9, 0), 20'h0A000 + 20'(r), 0);
    for (int k = 1; k < 4; k++) fill(vpn_of(9, k), ppn_of(vpn_of(9, k)), 0);
    expect_entry("R5 refill in place", vpn_of(9, 0), 1, 20'h0A003);
    for (int k = 1; k < 4; k++)
      expect_entry("R5 no eviction", vpn_of(9, k), 1, ppn_of(vpn_of(9, k)));

    // R6: tree pseudo-LRU victim over many hit patterns
    do_reset();
    mb = 3'b000;
    for (int k = 0; k < 4; k++) begin
      way_vpn[k] = vpn_of(6, k);
      fill(way_vpn[k], ppn_of(way_vpn[k]), 0);
      mb = m_touch(mb, k);
    end
    for (int r = 0; r < 8; r++) begin
      logic [19:0] nv, old;
      int vic;
      for (int j = 0; j < 4; j++) begin
        if (((r * 5 + j * 3) % 4) < 2) begin
          expect_entry("R6 touch", way_vpn[j], 1, ppn_of(way_vpn[j]));
          mb = m_touch(mb, j);
        end
      end
      nv = vpn_of(6, 10 + r);
      vic = m_victim(mb);
      fill(nv, ppn_of(nv), 0);
      mb = m_touch(mb, vic);
      old = way_vpn[vic];
      way_vpn[vic] = nv;
      expect_entry("R6 victim evicted", old, 0, '0);
      for (int j = 0; j < 4; j++) begin
        expect_entry("R6 survivors", way_vpn[j], 1, ppn_of(way_vpn[j]));
        mb = m_touch(mb, j);
      end
    end

    // R8: single-page invalidate removes a global entry
    do_reset();
    fill(vpn_of(4, 0), ppn_of(vpn_of(4, 0)), 1);
    fill(vpn_of(4, 1), ppn_of(vpn_of(4, 1)), 1);
    @(negedge clk);
    inv_valid = 1; inv_vpn = vpn_of(4, 7);
    @(negedge clk);
    inv_valid = 0;
    expect_entry("R8 absent page no effect", vpn_of(4, 0), 1, ppn_of(vpn_of(4, 0)));
    @(negedge clk);
    inv_valid = 1; inv_vpn = vpn_of(4, 0);
    @(negedge clk);
    inv_valid = 0;
    expect_entry("R8 global removed", vpn_of(4, 0), 0, '0);
    expect_entry("R8 neighbour kept", vpn_of(4, 1), 1, ppn_of(vpn_of(4, 1)));

    // R9: snoop reaches aliases in different sets
    do_reset();
    fill(vpn_of(2, 9), 20'h5BEEF, 1);
    fill(vpn_of(11, 9), 20'h5BEEF, 0);
    fill(vpn_of(2, 0), ppn_of(vpn_of(2, 0)), 0);
    @(negedge clk);
    snoop_valid = 1; snoop_ppn = 20'h5BEEF;
    @(negedge clk);
    snoop_valid = 0;
    expect_entry("R9 alias set 2", vpn_of(2, 9), 0, '0);
    expect_entry("R9 alias set 11", vpn_of(11, 9), 0, '0);
    expect_entry("R9 other kept", vpn_of(2, 0), 1, ppn_of(vpn_of(2, 0)));

    // R10: lookup in the same cycle as maintenance sees post state
    do_reset();
    fill(vpn_of(3, 0), ppn_of(vpn_of(3, 0)), 1);
    fill(vpn_of(3, 1), ppn_of(vpn_of(3, 1)), 0);
    fill(vpn_of(8, 2), ppn_of(vpn_of(8, 2)), 0);
    look(vpn_of(3, 0), 1, 0, '0, h, p, a, rv);
    chk("R10 global with flush", {31'd0, h}, 1);
    look(vpn_of(3, 1), 1, 0, '0, h, p, a, rv);
    chk("R10 local with flush", {31'd0, h}, 0);
    look(vpn_of(8, 2), 0, 1, vpn_of(8, 2), h, p, a, rv);
    chk("R10 invalidate same cycle", {31'd0, h}, 0);
    @(negedge clk);
    lk_valid = 1; lk_vpn = vpn_of(3, 0);
    snoop_valid = 1; snoop_ppn = ppn_of(vpn_of(3, 0));
    @(negedge clk);
    lk_valid = 0; snoop_valid = 0;
    chk("R10 snoop same cycle", {31'd0, rsp_hit}, 0);

    finish_run();
  end

endmodule